// File: doc/BRIEF.md
# Output-Stationary Distance Systolic Array

This block is a two-dimensional grid of processing elements that measures how far a patch template lies from a set of feature-map windows. Each element owns one output position and builds that output's squared Euclidean distance on its own. For every accumulation step it adds the squared difference between a feature byte and a template byte to a private accumulator. Partial sums never leave an element, so no adder tree is needed. Feature bytes enter at the left edge, one lane per row, and move right one element per advance. Template bytes enter at the top edge, one lane per column, and move down one element per advance. Because each value is forwarded between neighbours, it is fetched from memory only once.

A job starts with a start pulse that carries a kernel edge size k. The array then takes k·k·CHANS beats. On each beat, every row lane carries its feature byte and every column lane carries its template byte, all presented together without skew. The array adds the diagonal skew itself: it delays row i by i advances and column j by j advances. After the last beat has reached the far corner, the block raises a done pulse. It then shifts all results out on a single serial port in row-major order. The same array is reused for one template after another, and each new start clears every accumulator.

Top module: `patch_dist_array`

## Requirements
- R1: Out of reset, done and res_valid are 0 and res_data is 0. Whenever res_valid is 0, res_data is 0.
- R2: With N = k·k·CHANS, the result for element (i,j) is the sum over beats b = 0..N-1 of (feat_i[b] − tmpl_j[b])². Here feat_i is feat_data bits [i·DW +: DW] and tmpl_j is tmpl_data bits [j·DW +: DW], both unsigned.
- R3: ksize is taken at the start pulse and may be any value from 1 to KMAX. A start pulse with ksize 0 or ksize above KMAX is ignored: no done pulse follows and no result is produced.
- R4: A beat is accepted only on a cycle where feat_valid and tmpl_valid are both 1. On any other cycle the data lanes are ignored, and every skew register and accumulator keeps its value.
- R5: done is a one-cycle pulse. If no stall occurs after the first beat, done is high in the cycle after clock edge F + N + ROWS + COLS − 3, where F is the edge that accepts the first beat.
- R6: res_valid is high for exactly ROWS·COLS consecutive cycles. The first of these cycles is the cycle in which done is high. Results come out in row-major order: element (0,0), then (0,1), and so on.
- R7: A start pulse is ignored from the cycle after an accepted start until the last result has been shifted out. This covers the run, the flush and the drain.
- R8: Each accepted start clears every accumulator, so a job's results do not depend on earlier jobs.
- R9: With k = KMAX and byte differences of 255, every accumulator holds N·65025 exactly, without wrapping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Job start pulse, accepted only while idle |
| ksize | input | $clog2(KMAX+1) | Kernel edge size k for the job |
| feat_valid | input | 1 | Feature lanes hold a beat |
| feat_data | input | ROWS·DW | One feature byte per row, row i at [i·DW +: DW] |
| tmpl_valid | input | 1 | Template lanes hold a beat |
| tmpl_data | input | COLS·DW | One template byte per column, column j at [j·DW +: DW] |
| done | output | 1 | One-cycle pulse marking the first result cycle |
| res_valid | output | 1 | res_data carries a result |
| res_data | output | AW | Serial distance result, row-major |

## Verification
The bench targets four corner cases.

- Random stalls: the two valid flags drop independently, and garbage data is driven on those cycles. A design that advanced on one flag alone, or kept accumulating on a stalled cycle, would produce sums off by stray squared terms.
- Kernel size: jobs use k = 1, 2, 3, 5 and KMAX, plus the illegal sizes 0 and KMAX+1. A wrong beat count or a missing legality check would show up as wrong totals or a spurious done pulse.
- Extreme data: the maximum-difference job exposes an accumulator that is too narrow, because the sum would wrap.
- Start while busy: start pulses are placed in the middle of a run and during the drain. A design that restarted on them would clear partial sums, cut the drain short, or emit a second burst of results that the scoreboard does not expect.

// File: rtl/pda_pkg.sv
package pda_pkg;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_RUN   = 2'd1,
      ST_FLUSH = 2'd2,
      ST_DRAIN = 2'd3
   } pda_state_e;

   function automatic int pda_max(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

   function automatic int pda_bits(input int v);
      return (v <= 1) ? 1 : $clog2(v + 1);
   endfunction

endpackage

// File: rtl/pda_delay_line.sv
// Tapped delay line: tap[n] is din delayed by OFS+n enabled advances.
module pda_delay_line #(
   parameter int W    = 9,
   parameter int OFS  = 0,
   parameter int NTAP = 4,
   localparam int LEN = OFS + NTAP - 1
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     clr,
   input  logic                     en,
   input  logic [W-1:0]             din,
   output logic [NTAP-1:0][W-1:0]   tap
);

   if (LEN == 0) begin : g_wire
      assign tap[0] = din;
   end else begin : g_regs
      logic [W-1:0] sr [1:LEN];

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            for (int s = 1; s <= LEN; s++) sr[s] <= '0;
         end else if (clr) begin
            for (int s = 1; s <= LEN; s++) sr[s] <= '0;
         end else if (en) begin
            sr[1] <= din;
            for (int s = 2; s <= LEN; s++) sr[s] <= sr[s-1];
         end
      end

      for (genvar n = 0; n < NTAP; n++) begin : g_tap
         if (OFS + n == 0) begin : g_direct
            assign tap[n] = din;
         end else begin : g_delayed
            assign tap[n] = sr[OFS+n];
         end
      end
   end

endmodule

// File: rtl/pda_pe.sv
// One element: squared-difference accumulator that doubles as a drain stage.
module pda_pe #(
   parameter int DW = 8,
   parameter int AW = 26
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr,
   input  logic          en,
   input  logic          shift,
   input  logic [DW-1:0] f,
   input  logic          f_tag,
   input  logic [DW-1:0] t,
   input  logic [AW-1:0] chain_in,
   output logic [AW-1:0] acc
);

   localparam int SW = 2 * DW;

   logic [DW-1:0] diff;
   logic [SW-1:0] sq;

   assign diff = (f >= t) ? (f - t) : (t - f);
   assign sq   = SW'(diff) * SW'(diff);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc <= '0;
      end else if (clr) begin
         acc <= '0;
      end else if (shift) begin
         acc <= chain_in;
      end else if (en && f_tag) begin
         acc <= acc + AW'(sq);
      end
   end

endmodule

// File: rtl/pda_ctrl.sv
// Job sequencer: run (beats), flush (skew emptying), drain (serial shift).
module pda_ctrl
   import pda_pkg::*;
#(
   parameter int ROWS  = 4,
   parameter int COLS  = 4,
   parameter int KMAX  = 16,
   parameter int CHANS = 4,
   parameter int KSW   = 5,
   parameter int CW    = 11
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           start,
   input  logic [KSW-1:0] ksize,
   input  logic           fv,
   input  logic           tv,
   output logic           adv,
   output logic           tag,
   output logic           clr,
   output logic           shift,
   output logic           done,
   output logic           res_valid
);

   localparam int  FLUSH_LEN = ROWS + COLS - 2;
   localparam int  RC        = ROWS * COLS;
   localparam bit  HAS_FLUSH = (FLUSH_LEN > 0);

   pda_state_e    state_q;
   logic [CW-1:0] cnt_q;
   logic [CW-1:0] nbeats_q;
   logic          done_q;
   logic          k_ok;
   logic          start_ok;
   logic          last_beat;
   logic          last_flush;
   logic          last_drain;

   assign k_ok       = (ksize != '0) && (ksize <= KSW'(KMAX));
   assign start_ok   = start && (state_q == ST_IDLE) && k_ok;
   assign adv        = ((state_q == ST_RUN) && fv && tv) || (state_q == ST_FLUSH);
   assign tag        = (state_q == ST_RUN);
   assign clr        = start_ok;
   assign shift      = (state_q == ST_DRAIN);
   assign res_valid  = shift;
   assign done       = done_q;
   assign last_beat  = (cnt_q == nbeats_q - CW'(1));
   assign last_flush = (cnt_q == CW'(FLUSH_LEN - 1));
   assign last_drain = (cnt_q == CW'(RC - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q  <= ST_IDLE;
         cnt_q    <= '0;
         nbeats_q <= '0;
         done_q   <= 1'b0;
      end else begin
         done_q <= 1'b0;
         unique case (state_q)
            ST_IDLE: begin
               if (start_ok) begin
                  nbeats_q <= CW'(ksize) * CW'(ksize) * CW'(CHANS);
                  cnt_q    <= '0;
                  state_q  <= ST_RUN;
               end
            end
            ST_RUN: begin
               if (adv) begin
                  if (last_beat) begin
                     cnt_q <= '0;
                     if (HAS_FLUSH) begin
                        state_q <= ST_FLUSH;
                     end else begin
                        state_q <= ST_DRAIN;
                        done_q  <= 1'b1;
                     end
                  end else begin
                     cnt_q <= cnt_q + CW'(1);
                  end
               end
            end
            ST_FLUSH: begin
               if (last_flush) begin
                  cnt_q   <= '0;
                  state_q <= ST_DRAIN;
                  done_q  <= 1'b1;
               end else begin
                  cnt_q <= cnt_q + CW'(1);
               end
            end
            ST_DRAIN: begin
               if (last_drain) begin
                  cnt_q   <= '0;
                  state_q <= ST_IDLE;
               end else begin
                  cnt_q <= cnt_q + CW'(1);
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/patch_dist_array.sv
module patch_dist_array
   import pda_pkg::*;
#(
   parameter int  ROWS  = 4,
   parameter int  COLS  = 4,
   parameter int  DW    = 8,
   parameter int  KMAX  = 16,
   parameter int  CHANS = 4,
   localparam int KSW   = $clog2(KMAX + 1),
   localparam int NMAX  = KMAX * KMAX * CHANS,
   localparam int AW    = 2 * DW + $clog2(NMAX)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 start,
   input  logic [KSW-1:0]       ksize,
   input  logic                 feat_valid,
   input  logic [ROWS*DW-1:0]   feat_data,
   input  logic                 tmpl_valid,
   input  logic [COLS*DW-1:0]   tmpl_data,
   output logic                 done,
   output logic                 res_valid,
   output logic [AW-1:0]        res_data
);

   localparam int RC = ROWS * COLS;
   localparam int CW = pda_bits(pda_max(pda_max(NMAX, RC), ROWS + COLS));

   if (ROWS < 1 || COLS < 1) begin : g_bad_grid
      $error("patch_dist_array: grid must be at least 1x1");
   end
   if (DW < 1) begin : g_bad_dw
      $error("patch_dist_array: DW must be positive");
   end
   if (KMAX < 1 || CHANS < 1) begin : g_bad_win
      $error("patch_dist_array: KMAX and CHANS must be positive");
   end

   logic adv_w;
   logic tag_w;
   logic clr_w;
   logic shift_w;

   pda_ctrl #(
      .ROWS (ROWS),
      .COLS (COLS),
      .KMAX (KMAX),
      .CHANS(CHANS),
      .KSW  (KSW),
      .CW   (CW)
   ) u_ctrl (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (start),
      .ksize    (ksize),
      .fv       (feat_valid),
      .tv       (tmpl_valid),
      .adv      (adv_w),
      .tag      (tag_w),
      .clr      (clr_w),
      .shift    (shift_w),
      .done     (done),
      .res_valid(res_valid)
   );

   // Row lanes carry the byte plus a beat tag; column lanes carry the byte only.
   logic [COLS-1:0][DW:0]   row_tap [ROWS];
   logic [ROWS-1:0][DW-1:0] col_tap [COLS];
   logic [RC-1:0][AW-1:0]   acc_bus;

   for (genvar i = 0; i < ROWS; i++) begin : g_row
      pda_delay_line #(
         .W   (DW + 1),
         .OFS (i),
         .NTAP(COLS)
      ) u_rdl (
         .clk  (clk),
         .rst_n(rst_n),
         .clr  (clr_w),
         .en   (adv_w),
         .din  ({tag_w, feat_data[i*DW +: DW]}),
         .tap  (row_tap[i])
      );
   end

   for (genvar j = 0; j < COLS; j++) begin : g_col
      pda_delay_line #(
         .W   (DW),
         .OFS (j),
         .NTAP(ROWS)
      ) u_cdl (
         .clk  (clk),
         .rst_n(rst_n),
         .clr  (clr_w),
         .en   (adv_w),
         .din  (tmpl_data[j*DW +: DW]),
         .tap  (col_tap[j])
      );
   end

   for (genvar i = 0; i < ROWS; i++) begin : g_pe_r
      for (genvar j = 0; j < COLS; j++) begin : g_pe_c
         localparam int E = i * COLS + j;
         logic [AW-1:0] chain_w;

         if (E == RC - 1) begin : g_tail
            assign chain_w = '0;
         end else begin : g_link
            assign chain_w = acc_bus[E+1];
         end

         pda_pe #(
            .DW(DW),
            .AW(AW)
         ) u_pe (
            .clk     (clk),
            .rst_n   (rst_n),
            .clr     (clr_w),
            .en      (adv_w),
            .shift   (shift_w),
            .f       (row_tap[i][j][DW-1:0]),
            .f_tag   (row_tap[i][j][DW]),
            .t       (col_tap[j][i]),
            .chain_in(chain_w),
            .acc     (acc_bus[E])
         );
      end
   end

   assign res_data = res_valid ? acc_bus[0] : '0;

endmodule

// File: rtl/pda_checker.sv
module pda_checker #(
   parameter int ROWS = 4,
   parameter int COLS = 4,
   parameter int AW   = 26
) (
   input logic                           clk,
   input logic                           rst_n,
   input logic                           done,
   input logic                           res_valid,
   input logic [AW-1:0]                  res_data,
   input logic                           adv,
   input logic                           clr,
   input logic                           shift,
   input logic [ROWS*COLS-1:0][AW-1:0]   accs
);

   localparam int RC = ROWS * COLS;

   int unsigned run_len;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) run_len <= 0;
      else if (res_valid) run_len <= run_len + 1;
      else run_len <= 0;
   end

   assert_quiet_output_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !res_valid |-> (res_data == '0));

   assert_done_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   assert_done_opens_drain_R6: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (res_valid && !$past(res_valid)));

   assert_drain_length_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(res_valid) |-> (run_len == RC));

   assert_no_restart_in_drain_R7: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(res_valid) && res_valid) |-> !done);

   assert_stall_freeze_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (!adv && !shift && !clr) |=> $stable(accs));

   for (genvar e = 0; e < RC; e++) begin : g_acc
      assert_no_overflow_R9: assert property (@(posedge clk) disable iff (!rst_n)
         (adv && !clr && !shift) |=> (accs[e] >= $past(accs[e])));
   end

endmodule

bind patch_dist_array pda_checker #(
   .ROWS(ROWS),
   .COLS(COLS),
   .AW  (AW)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .done     (done),
   .res_valid(res_valid),
   .res_data (res_data),
   .adv      (adv_w),
   .clr      (clr_w),
   .shift    (shift_w),
   .accs     (acc_bus)
);

// File: tb/sim_patch_dist_array.sv
`timescale 1ns/1ps
module sim_patch_dist_array;

   localparam int ROWS  = 4;
   localparam int COLS  = 4;
   localparam int DW    = 8;
   localparam int KMAX  = 16;
   localparam int CHANS = 4;
   localparam int KSW   = $clog2(KMAX + 1);
   localparam int NMAX  = KMAX * KMAX * CHANS;
   localparam int AW    = 2 * DW + $clog2(NMAX);
   localparam int RC    = ROWS * COLS;
   localparam int LIMIT = 150000;

   logic                 clk = 1'b0;
   logic                 rst_n = 1'b0;
   logic                 start = 1'b0;
   logic [KSW-1:0]       ksize = '0;
   logic                 feat_valid = 1'b0;
   logic [ROWS*DW-1:0]   feat_data = '0;
   logic                 tmpl_valid = 1'b0;
   logic [COLS*DW-1:0]   tmpl_data = '0;
   logic                 done;
   logic                 res_valid;
   logic [AW-1:0]        res_data;

   patch_dist_array #(
      .ROWS(ROWS), .COLS(COLS), .DW(DW), .KMAX(KMAX), .CHANS(CHANS)
   ) u0 (
      .clk(clk), .rst_n(rst_n), .start(start), .ksize(ksize),
      .feat_valid(feat_valid), .feat_data(feat_data),
      .tmpl_valid(tmpl_valid), .tmpl_data(tmpl_data),
      .done(done), .res_valid(res_valid), .res_data(res_data)
   );

   always #2.5 clk = ~clk;

   int          cyc = 0;
   int          total = 0;
   int          bad = 0;
   int          done_cnt = 0;
   int          done_cyc = 0;
   bit          prev_rv = 1'b0;
   bit          wd_fired = 1'b0;
   logic [31:0] exp_q [$];
   logic [7:0]  fa [ROWS][NMAX];
   logic [7:0]  ta [COLS][NMAX];

   always @(posedge clk) cyc <= cyc + 1;

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] expv);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, expv, cyc);
      end
   endtask

   // Monitor: scoreboard pop and done bookkeeping.
   always @(negedge clk) begin
      if (rst_n) begin
         if (done) begin
            done_cnt++;
            done_cyc = cyc;
            chk(res_valid && !prev_rv, "R6 done opens drain", {31'd0, res_valid}, 32'd1);
         end
         if (res_valid) begin
            if (exp_q.size() == 0) begin
               chk(1'b0, "R7 unexpected result", 32'(res_data), 32'd0);
            end else begin
               logic [31:0] e;
               e = exp_q.pop_front();
               chk(32'(res_data) == e, "R2 distance", 32'(res_data), e);
            end
         end else begin
            chk(res_data == '0, "R1 idle data", 32'(res_data), 32'd0);
         end
         prev_rv = res_valid;
      end
   end

   always @(negedge clk) begin
      if (cyc > LIMIT && !wd_fired) begin
         wd_fired = 1'b1;
         total++;
         bad++;
         $display("FAIL watchdog actual=%0d expected<%0d", cyc, LIMIT);
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   // Driver: builds the job, pushes row-major expectations, then feeds beats.
   task automatic run_job(input int k, input bit stall, input int pat,
                          input bit mid_start, input bit drain_start, input bit chk_lat);
      int n;
      int b;
      int first;
      int d0;
      n = k * k * CHANS;
      for (int i = 0; i < ROWS; i++)
         for (int s = 0; s < n; s++)
            fa[i][s] = (pat == 1) ? ((i % 2 == 0) ? 8'd255 : 8'd0) : 8'($urandom);
      for (int j = 0; j < COLS; j++)
         for (int s = 0; s < n; s++)
            ta[j][s] = (pat == 1) ? ((j % 2 == 0) ? 8'd0 : 8'd255) : 8'($urandom);
      for (int i = 0; i < ROWS; i++)
         for (int j = 0; j < COLS; j++) begin
            longint sum;
            sum = 0;
            for (int s = 0; s < n; s++) begin
               int dd;
               dd = int'(fa[i][s]) - int'(ta[j][s]);
               sum += longint'(dd * dd);
            end
            exp_q.push_back(32'(sum));
         end
      d0 = done_cnt;
      @(negedge clk);
      start = 1'b1;
      ksize = KSW'(k);
      @(negedge clk);
      start = 1'b0;
      b = 0;
      first = 0;
      while (b < n) begin
         bit fv;
         bit tv;
         fv = stall ? ($urandom % 4 != 0) : 1'b1;
         tv = stall ? ($urandom % 3 != 0) : 1'b1;
         feat_valid = fv;
         tmpl_valid = tv;
         start = (mid_start && b == n / 2);
         ksize = mid_start ? KSW'(1) : KSW'(k);
         for (int i = 0; i < ROWS; i++)
            feat_data[i*DW +: DW] = (fv && tv) ? fa[i][b] : 8'($urandom);
         for (int j = 0; j < COLS; j++)
            tmpl_data[j*DW +: DW] = (fv && tv) ? ta[j][b] : 8'($urandom);
         if (fv && tv) begin
            if (b == 0) first = cyc + 1;
            b++;
         end
         @(negedge clk);
      end
      feat_valid = 1'b0;
      tmpl_valid = 1'b0;
      start = 1'b0;
      while (done_cnt == d0) @(negedge clk);
      if (chk_lat)
         chk(done_cyc - first == n + ROWS + COLS - 3, "R5 done latency",
             32'(done_cyc - first), 32'(n + ROWS + COLS - 3));
      if (drain_start) begin
         @(negedge clk);
         start = 1'b1;
         ksize = KSW'(1);
         @(negedge clk);
         start = 1'b0;
      end
      while (res_valid) @(negedge clk);
      chk(exp_q.size() == 0, "R6 drain count", 32'(exp_q.size()), 32'd0);
      chk(done_cnt == d0 + 1, "R5 single done", 32'(done_cnt - d0), 32'd1);
      if (drain_start) begin
         repeat (40) @(negedge clk);
         chk(done_cnt == d0 + 1, "R7 start during drain ignored", 32'(done_cnt - d0), 32'd1);
      end
   endtask

   task automatic bad_size(input int k);
      int d0;
      d0 = done_cnt;
      @(negedge clk);
      start = 1'b1;
      ksize = KSW'(k);
      @(negedge clk);
      start = 1'b0;
      feat_valid = 1'b1;
      tmpl_valid = 1'b1;
      repeat (10) @(negedge clk);
      feat_valid = 1'b0;
      tmpl_valid = 1'b0;
      repeat (40) @(negedge clk);
      chk(done_cnt == d0, "R3 illegal ksize ignored", 32'(done_cnt - d0), 32'd0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      chk(done == 1'b0, "R1 reset done", {31'd0, done}, 32'd0);
      chk(res_valid == 1'b0, "R1 reset valid", {31'd0, res_valid}, 32'd0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(res_data == '0, "R1 reset data", 32'(res_data), 32'd0);

      run_job(2, 1'b0, 0, 1'b0, 1'b0, 1'b1);          // R2 R5 R6 plain run
      run_job(3, 1'b1, 0, 1'b1, 1'b0, 1'b0);          // R4 stalls, R7 start mid-run, R8 fresh job
      run_job(1, 1'b0, 0, 1'b0, 1'b0, 1'b1);          // R3 smallest kernel
      bad_size(0);                                    // R3 zero size
      bad_size(KMAX + 1);                             // R3 oversize
      run_job(5, 1'b1, 0, 1'b0, 1'b1, 1'b0);          // R7 start during drain
      run_job(KMAX, 1'b0, 1, 1'b0, 1'b0, 1'b1);       // R9 widest sums, R3 largest kernel
      run_job(2, 1'b0, 0, 1'b0, 1'b0, 1'b1);          // R8 back-to-back after extremes

      repeat (5) @(negedge clk);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule